// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns one 16-bit compressed instruction of the RV32 integer subset into the 32-bit base instruction that has the same effect, together with a flag that marks the halfword as illegal. It sits between the fetch aligner and the main decoder. The rest of the pipeline then sees only full-width instructions. The covered forms are:

- Quadrant 0: the stack-pointer-based address add, and word load and word store.
- Quadrant 1: add-immediate, load-immediate, the slot shared by stack adjustment and load-upper-immediate, the right shifts, and and-immediate.
- Quadrant 2: the left shift, word load and store relative to the stack pointer, and the register group that holds jump-register, move, breakpoint, jump-and-link-register and add.

Every other encoding is reported as illegal. Quadrant 3 (a non-compressed word) is reported as illegal too.

Slots where several instructions share one opcode are settled by checks in priority order on the register and immediate fields. Reserved encodings are caught explicitly, and so are hint encodings. A parameter selects whether the result is registered (latency one cycle, the default) or purely combinational.

Top module: `cinst_expand`

## Requirements
- R1: Bits 1:0 pick the quadrant and bits 15:13 the opcode slot. Any encoding outside the covered forms asserts `illegal`. This includes quadrant 3, the floating-point forms, the 64-bit-only forms, jumps, branches and the register-register arithmetic of quadrant 1.
- R2: The halfword 0x0000 asserts `illegal`.
- R3: Quadrant 0, slot 000: the immediate is {b10:7, b12:11, b5, b6, 00}, zero-extended. The result is ADDI rd', x2, imm, with rd' = 8 + b4:2. A zero immediate is reserved and asserts `illegal`.
- R4: Quadrant 0, slots 010 and 110: these give LW rd', off(rs1') and SW rs2', off(rs1'). The offset is {b5, b12:10, b6, 00}, zero-extended. rs1' = 8 + b9:7, and rd' or rs2' = 8 + b4:2.
- R5: Quadrant 1, slot 000 gives ADDI rd, rd, imm. Slot 010 gives ADDI rd, x0, imm. In both, rd = b11:7 and imm is {b12, b6:2}, sign-extended.
- R6: Quadrant 1, slot 011 with b11:7 = 2 gives ADDI x2, x2, imm. The imm is {b12, b4:3, b5, b2, b6, 0000}, sign-extended. A zero imm asserts `illegal`.
- R7: Quadrant 1, slot 011 with any other rd gives LUI rd, imm. The imm is {b12, b6:2}, sign-extended to 20 bits. A zero imm asserts `illegal`. With rd = 0 and a non-zero imm, the output is 0x00000013, which has no architectural effect.
- R8: Quadrant 1, slot 100: b11:10 = 00, 01 and 10 give SRLI, SRAI and ANDI with rd = rs1 = 8 + b9:7. The shift amount is b6:2, and the and-immediate is {b12, b6:2}, sign-extended. A shift with b12 = 1 asserts `illegal`.
- R9: Quadrant 2: slot 000 gives SLLI rd, rd, b6:2, and is illegal when b12 = 1. Slot 010 gives LW rd, off(x2), with off = {b3:2, b12, b6:4, 00}; it is illegal when rd = 0. Slot 110 gives SW rs2, off(x2), with off = {b8:7, b12:9, 00} and rs2 = b6:2.
- R10: Quadrant 2, slot 100 with b12 = 0: rs2 = 0 gives JALR x0, 0(rd). A non-zero rs2 gives ADD rd, x0, rs2. rs2 = 0 together with rd = 0 asserts `illegal`.
- R11: Quadrant 2, slot 100 with b12 = 1, checked in this order: rd = rs2 = 0 gives EBREAK (0x00100073). Otherwise rs2 = 0 gives JALR x1, 0(rd). Otherwise the result is ADD rd, rd, rs2.
- R12: Whenever `illegal` is 1, `expInsn` is 0x00000000.
- R13: With REG_OUT = 1, both outputs follow the input one clock later. While `rstN` is low they are held at 0.
- R14: For every input with bits 1:0 other than 11, `expInsn` and `illegal` carry no unknown bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| cInsn | input | 16 | Compressed instruction halfword |
| expInsn | output | 32 | Expanded 32-bit instruction, zero when illegal |
| illegal | output | 1 | High when the halfword is reserved, unsupported or invalid |

## Verification
With the default registered build, each expanded word and its illegal flag are due on the first rising edge after the halfword is applied. The bench drives every halfword on a falling edge and compares both outputs at the next falling edge, one full cycle later. A directed step applies a new halfword and looks again shortly after, before the next rising edge, to confirm the old result is still held. During the exhaustive sweep, each new input is driven right after the previous result has been sampled, so every comparison falls exactly one cycle after its own stimulus.

// File: rtl/cexp_pkg.sv
package cexp_pkg;

  localparam int HalfW = 16;
  localparam int WordW = 32;
  localparam int RegW  = 5;
  localparam int ImmW  = 12;
  localparam int UpW   = 20;

  localparam logic [6:0] OpImm   = 7'b0010011;
  localparam logic [6:0] OpLoad  = 7'b0000011;
  localparam logic [6:0] OpStore = 7'b0100011;
  localparam logic [6:0] OpReg   = 7'b0110011;
  localparam logic [6:0] OpLui   = 7'b0110111;
  localparam logic [6:0] OpJalr  = 7'b1100111;
  localparam logic [WordW-1:0] EbreakWord = 32'h0010_0073;
  localparam logic [WordW-1:0] NopWord    = 32'h0000_0013;

  typedef enum logic [4:0] {
    FORM_NONE, FORM_SPADD, FORM_LW, FORM_SW, FORM_ADDI, FORM_LI,
    FORM_SPADJ, FORM_LUI, FORM_NOP, FORM_SRLI, FORM_SRAI, FORM_ANDI,
    FORM_SLLI, FORM_LWSP, FORM_SWSP, FORM_JR, FORM_MV, FORM_EBREAK,
    FORM_JALR, FORM_ADD
  } formT;

  typedef struct packed {
    formT form;
    logic illegal;
  } ctrlT;

  function automatic logic [RegW-1:0] compactReg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [WordW-1:0] encI(input logic [ImmW-1:0] imm,
      input logic [RegW-1:0] rs1, input logic [2:0] f3,
      input logic [RegW-1:0] rd, input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [WordW-1:0] encS(input logic [ImmW-1:0] imm,
      input logic [RegW-1:0] rs2, input logic [RegW-1:0] rs1,
      input logic [2:0] f3, input logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic logic [WordW-1:0] encR(input logic [6:0] f7,
      input logic [RegW-1:0] rs2, input logic [RegW-1:0] rs1,
      input logic [2:0] f3, input logic [RegW-1:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [WordW-1:0] encU(input logic [UpW-1:0] imm,
      input logic [RegW-1:0] rd, input logic [6:0] op);
    return {imm, rd, op};
  endfunction

endpackage

// File: rtl/cexp_decode.sv
module cexp_decode
  import cexp_pkg::*;
(
  input  logic [HalfW-1:0] cInsn,
  output ctrlT             ctl
);

  logic [1:0]      quad;
  logic [2:0]      slot;
  logic            bitTop;
  logic [RegW-1:0] rdField;
  logic [RegW-1:0] rs2Field;
  logic            ciNonZero;
  formT            form;

  assign quad      = cInsn[1:0];
  assign slot      = cInsn[15:13];
  assign bitTop    = cInsn[12];
  assign rdField   = cInsn[11:7];
  assign rs2Field  = cInsn[6:2];
  assign ciNonZero = |{bitTop, cInsn[6:2]};

  always_comb begin
    form = FORM_NONE;
    unique case (quad)
      2'b00: begin
        unique case (slot)
          3'b000:  if (|cInsn[12:5]) form = FORM_SPADD;
          3'b010:  form = FORM_LW;
          3'b110:  form = FORM_SW;
          default: form = FORM_NONE;
        endcase
      end
      2'b01: begin
        unique case (slot)
          3'b000: form = FORM_ADDI;
          3'b010: form = FORM_LI;
          3'b011: begin
            // stack adjustment wins over the upper-immediate load
            if (rdField == RegW'(2)) begin
              if (ciNonZero) form = FORM_SPADJ;
            end else if (ciNonZero) begin
              form = (rdField == '0) ? FORM_NOP : FORM_LUI;
            end
          end
          3'b100: begin
            if (cInsn[11:10] == 2'b10)       form = FORM_ANDI;
            else if (cInsn[11:10] == 2'b00)  form = bitTop ? FORM_NONE : FORM_SRLI;
            else if (cInsn[11:10] == 2'b01)  form = bitTop ? FORM_NONE : FORM_SRAI;
          end
          default: form = FORM_NONE;
        endcase
      end
      2'b10: begin
        unique case (slot)
          3'b000: if (!bitTop) form = FORM_SLLI;
          3'b010: if (rdField != '0) form = FORM_LWSP;
          3'b110: form = FORM_SWSP;
          3'b100: begin
            if (!bitTop) begin
              if (rs2Field != '0)      form = FORM_MV;
              else if (rdField != '0)  form = FORM_JR;
            end else begin
              if (rdField == '0 && rs2Field == '0) form = FORM_EBREAK;
              else if (rs2Field == '0)             form = FORM_JALR;
              else                                 form = FORM_ADD;
            end
          end
          default: form = FORM_NONE;
        endcase
      end
      default: form = FORM_NONE;
    endcase
  end

  assign ctl.form    = form;
  assign ctl.illegal = (form == FORM_NONE);

endmodule

// File: rtl/cexp_build.sv
module cexp_build
  import cexp_pkg::*;
(
  input  logic [HalfW-1:0] cInsn,
  input  ctrlT             ctl,
  output logic [WordW-1:0] word
);

  logic [RegW-1:0] rdFull;
  logic [RegW-1:0] rs2Full;
  logic [RegW-1:0] rdComp;
  logic [RegW-1:0] rs1Comp;
  logic [ImmW-1:0] spAddImm;
  logic [ImmW-1:0] wordOff;
  logic [ImmW-1:0] ciImm;
  logic [ImmW-1:0] spAdjImm;
  logic [UpW-1:0]  luiImm;
  logic [ImmW-1:0] lwspOff;
  logic [ImmW-1:0] swspOff;
  logic [ImmW-1:0] shiftImm;
  logic [WordW-1:0] built;
  logic            unusedBits;

  assign unusedBits = ^{cInsn[15:13], cInsn[1:0]};

  assign rdFull   = cInsn[11:7];
  assign rs2Full  = cInsn[6:2];
  assign rdComp   = compactReg(cInsn[4:2]);
  assign rs1Comp  = compactReg(cInsn[9:7]);

  assign spAddImm = {2'b00, cInsn[10:7], cInsn[12:11], cInsn[5], cInsn[6], 2'b00};
  assign wordOff  = {5'b0, cInsn[5], cInsn[12:10], cInsn[6], 2'b00};
  assign ciImm    = {{6{cInsn[12]}}, cInsn[12], cInsn[6:2]};
  assign spAdjImm = {{2{cInsn[12]}}, cInsn[12], cInsn[4:3], cInsn[5], cInsn[2],
                     cInsn[6], 4'b0000};
  assign luiImm   = {{14{cInsn[12]}}, cInsn[12], cInsn[6:2]};
  assign lwspOff  = {4'b0, cInsn[3:2], cInsn[12], cInsn[6:4], 2'b00};
  assign swspOff  = {4'b0, cInsn[8:7], cInsn[12:9], 2'b00};
  assign shiftImm = {7'b0, cInsn[6:2]};

  always_comb begin
    built = '0;
    unique case (ctl.form)
      FORM_SPADD:  built = encI(spAddImm, RegW'(2), 3'b000, rdComp, OpImm);
      FORM_LW:     built = encI(wordOff, rs1Comp, 3'b010, rdComp, OpLoad);
      FORM_SW:     built = encS(wordOff, rdComp, rs1Comp, 3'b010, OpStore);
      FORM_ADDI:   built = encI(ciImm, rdFull, 3'b000, rdFull, OpImm);
      FORM_LI:     built = encI(ciImm, '0, 3'b000, rdFull, OpImm);
      FORM_SPADJ:  built = encI(spAdjImm, RegW'(2), 3'b000, RegW'(2), OpImm);
      FORM_LUI:    built = encU(luiImm, rdFull, OpLui);
      FORM_NOP:    built = NopWord;
      FORM_SRLI:   built = encI(shiftImm, rs1Comp, 3'b101, rs1Comp, OpImm);
      FORM_SRAI:   built = encI(shiftImm | 12'h400, rs1Comp, 3'b101, rs1Comp, OpImm);
      FORM_ANDI:   built = encI(ciImm, rs1Comp, 3'b111, rs1Comp, OpImm);
      FORM_SLLI:   built = encI(shiftImm, rdFull, 3'b001, rdFull, OpImm);
      FORM_LWSP:   built = encI(lwspOff, RegW'(2), 3'b010, rdFull, OpLoad);
      FORM_SWSP:   built = encS(swspOff, rs2Full, RegW'(2), 3'b010, OpStore);
      FORM_JR:     built = encI('0, rdFull, 3'b000, '0, OpJalr);
      FORM_MV:     built = encR(7'b0, rs2Full, '0, 3'b000, rdFull, OpReg);
      FORM_EBREAK: built = EbreakWord;
      FORM_JALR:   built = encI('0, rdFull, 3'b000, RegW'(1), OpJalr);
      FORM_ADD:    built = encR(7'b0, rs2Full, rdFull, 3'b000, rdFull, OpReg);
      default:     built = '0;
    endcase
  end

  assign word = ctl.illegal ? '0 : built;

endmodule

// File: rtl/cinst_expand.sv
module cinst_expand
  import cexp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [15:0]      cInsn,
  output logic [31:0]      expInsn,
  output logic             illegal
);

  ctrlT             ctl;
  logic [WordW-1:0] rawWord;

  cexp_decode uDecode (
    .cInsn (cInsn),
    .ctl   (ctl)
  );

  cexp_build uBuild (
    .cInsn (cInsn),
    .ctl   (ctl),
    .word  (rawWord)
  );

  generate
    if (REG_OUT) begin : gRegOut
      always_ff @(posedge clk) begin
        if (!rstN) begin
          expInsn <= '0;
          illegal <= 1'b0;
        end else begin
          expInsn <= rawWord;
          illegal <= ctl.illegal;
        end
      end

      assert_latency_R13: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> (expInsn == $past(rawWord)) && (illegal == $past(ctl.illegal)));
    end else begin : gCombOut
      assign expInsn = rawWord;
      assign illegal = ctl.illegal;
    end
  endgenerate

  assert_allzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cInsn == 16'h0000) |-> ctl.illegal);

  assert_quadrant3_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cInsn[1:0] == 2'b11) |-> ctl.illegal);

  assert_illegal_word_R12: assert property (@(posedge clk) disable iff (!rstN)
    ctl.illegal |-> (rawWord == '0));

  assert_ebreak_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cInsn == 16'h9002) |-> (rawWord == EbreakWord) && !ctl.illegal);

  assert_jr_rd0_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cInsn == 16'h8002) |-> ctl.illegal);

endmodule

// File: tb/tb_cinst_expand.sv
module tb_cinst_expand;

  localparam int NV = 33;

  typedef struct packed {
    logic [15:0] c;
    logic [31:0] w;
    logic        ill;
    logic [7:0]  req;
  } vecT;

  localparam vecT VECS [NV] = '{
    '{16'h0000, 32'h0000_0000, 1'b1, 8'd2},   // R2 all zero
    '{16'h0040, 32'h0041_0413, 1'b0, 8'd3},   // R3 addi x8,x2,4
    '{16'h0004, 32'h0000_0000, 1'b1, 8'd3},   // R3 zero immediate reserved
    '{16'h1FFC, 32'h3FC1_0793, 1'b0, 8'd3},   // R3 max immediate
    '{16'h4144, 32'h0045_2483, 1'b0, 8'd4},   // R4 lw x9,4(x10)
    '{16'hC02C, 32'h04B4_2023, 1'b0, 8'd4},   // R4 sw x11,64(x8)
    '{16'h2000, 32'h0000_0000, 1'b1, 8'd1},   // R1 floating load
    '{16'h12FD, 32'hFFF2_8293, 1'b0, 8'd5},   // R5 addi x5,x5,-1
    '{16'h4515, 32'h0050_0513, 1'b0, 8'd5},   // R5 li x10,5
    '{16'h713D, 32'hFE01_0113, 1'b0, 8'd6},   // R6 addi x2,x2,-32
    '{16'h6101, 32'h0000_0000, 1'b1, 8'd6},   // R6 zero reserved
    '{16'h6785, 32'h0000_17B7, 1'b0, 8'd7},   // R7 lui x15,1
    '{16'h757D, 32'hFFFF_F537, 1'b0, 8'd7},   // R7 lui x10,-1
    '{16'h6501, 32'h0000_0000, 1'b1, 8'd7},   // R7 zero immediate
    '{16'h6005, 32'h0000_0013, 1'b0, 8'd7},   // R7 rd=0 hint
    '{16'h800D, 32'h0034_5413, 1'b0, 8'd8},   // R8 srli x8,x8,3
    '{16'h84FD, 32'h41F4_D493, 1'b0, 8'd8},   // R8 srai x9,x9,31
    '{16'h9001, 32'h0000_0000, 1'b1, 8'd8},   // R8 shamt bit 5
    '{16'h9941, 32'hFF05_7513, 1'b0, 8'd8},   // R8 andi x10,x10,-16
    '{16'h8C01, 32'h0000_0000, 1'b1, 8'd1},   // R1 reg-reg arithmetic
    '{16'h0092, 32'h0040_9093, 1'b0, 8'd9},   // R9 slli x1,x1,4
    '{16'h40B2, 32'h00C1_2083, 1'b0, 8'd9},   // R9 lw x1,12(x2)
    '{16'h4032, 32'h0000_0000, 1'b1, 8'd9},   // R9 stack load rd=0
    '{16'hDFA2, 32'h0E81_2E23, 1'b0, 8'd9},   // R9 sw x8,252(x2)
    '{16'h1082, 32'h0000_0000, 1'b1, 8'd9},   // R9 slli shamt bit 5
    '{16'h8082, 32'h0000_8067, 1'b0, 8'd10},  // R10 jalr x0,0(x1)
    '{16'h8002, 32'h0000_0000, 1'b1, 8'd10},  // R10 jump-register rd=0
    '{16'h852E, 32'h00B0_0533, 1'b0, 8'd10},  // R10 add x10,x0,x11
    '{16'h9002, 32'h0010_0073, 1'b0, 8'd11},  // R11 ebreak
    '{16'h9282, 32'h0002_80E7, 1'b0, 8'd11},  // R11 jalr x1,0(x5)
    '{16'h952E, 32'h00B5_0533, 1'b0, 8'd11},  // R11 add x10,x10,x11
    '{16'h0003, 32'h0000_0000, 1'b1, 8'd1},   // R1 quadrant 3
    '{16'h2001, 32'h0000_0000, 1'b1, 8'd1}    // R1 jump-and-link slot
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cInsn = 16'h0000;
  logic [31:0] expInsn;
  logic        illegal;

  int totalCnt = 0;
  int passCnt  = 0;

  always #4 clk = ~clk;

  cinst_expand dut (
    .clk     (clk),
    .rstN    (rstN),
    .cInsn   (cInsn),
    .expInsn (expInsn),
    .illegal (illegal)
  );

  task automatic checkOut(input string tag, input logic [31:0] w, input logic ill);
    totalCnt++;
    if (expInsn === w && illegal === ill) begin
      passCnt++;
    end else begin
      $display("FAIL %s: actual word %h illegal %b, expected word %h illegal %b",
               tag, expInsn, illegal, w, ill);
    end
  endtask

  task automatic applyAndCheck(input string tag, input logic [15:0] c,
                               input logic [31:0] w, input logic ill);
    @(negedge clk);
    cInsn = c;
    @(negedge clk);
    checkOut(tag, w, ill);
  endtask

  initial begin
    #(8 * 190000);
    totalCnt++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    int sweepBad;
    int sweepIllBad;

    // R13: outputs held at zero during reset, even with a legal input applied
    cInsn = 16'h4515;
    repeat (3) @(negedge clk);
    checkOut("R13 reset", 32'h0, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      applyAndCheck($sformatf("R%0d vector %0d (%h)", VECS[i].req, i, VECS[i].c),
                    VECS[i].c, VECS[i].w, VECS[i].ill);
    end

    // R13: one-cycle latency, old result held until the next rising edge
    applyAndCheck("R13 first", 16'h4515, 32'h0050_0513, 1'b0);
    cInsn = 16'h9002;
    #2;
    checkOut("R13 hold before edge", 32'h0050_0513, 1'b0);
    @(negedge clk);
    checkOut("R13 after edge", 32'h0010_0073, 1'b0);

    // R11: hint add with rd=0 and non-zero rs2 is still an add
    applyAndCheck("R11 add rd=0", 16'h902E, 32'h00B0_0033, 1'b0);

    // R14 and R12: exhaustive sweep of compressed encodings
    sweepBad = 0;
    sweepIllBad = 0;
    @(negedge clk);
    cInsn = 16'h0000;
    for (int v = 1; v <= 65536; v++) begin
      @(negedge clk);
      if ($isunknown(expInsn) || $isunknown(illegal)) begin
        if (sweepBad < 4)
          $display("FAIL R14 input %h: actual word %h illegal %b, expected no unknown bits",
                   cInsn, expInsn, illegal);
        sweepBad++;
      end else if (illegal && expInsn != 32'h0) begin
        if (sweepIllBad < 4)
          $display("FAIL R12 input %h: actual word %h, expected 00000000", cInsn, expInsn);
        sweepIllBad++;
      end
      if (v < 65536) begin
        logic [15:0] nxt;
        nxt = 16'(v);
        if (nxt[1:0] == 2'b11) begin
          nxt = nxt + 16'd1;
          v++;
        end
        cInsn = nxt;
      end
    end
    totalCnt++;
    if (sweepBad == 0) passCnt++;
    totalCnt++;
    if (sweepIllBad == 0) passCnt++;

    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

endmodule